// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block handles the entry into a maskable interrupt for an 8-bit processor bus controller. At the final clock of every instruction the decode logic raises `instr_end_i`. On that clock edge the block checks three things: the active-low interrupt request level, a software-controlled enable flag, and the bus-request input. The request is accepted only when the request is low, the flag is set and no bus request is pending. Acceptance clears the enable flag. It then starts a special opcode-fetch machine cycle. During that cycle the I/O request strobe is asserted in place of the memory request strobe, so the interrupting device knows it must supply a response byte.

The acknowledge cycle always contains a fixed number of automatic wait states, which give a daisy-chained priority ripple time to settle. After the last automatic wait state, further wait states are added for as long as the external wait input is low. When the wait input is seen high at the end of a wait state, the byte on the data bus is captured and a one-cycle valid pulse is raised. A refresh phase follows, during which the refresh address is driven. The program counter is driven on the address bus at all other times.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, all active-low strobes (`m1_no`, `mreq_no`, `iorq_no`, `rd_no`, `rfsh_no`) are high, `ie_o` is 0, `vec_valid_o` is 0 and `vec_o` is 0.
- R2: On a rising edge where the block is idle and `instr_end_i`=1, `irq_ni`=0, `busrq_ni`=1 and `ie_o`=1, the request is accepted. In the next cycle `m1_no` is low and `ie_o` is 0.
- R3: While `instr_end_i` is 0, a low `irq_ni` never starts a cycle.
- R4: When `ie_o` is 0 at the sampling edge, a low `irq_ni` is ignored and `m1_no` stays high.
- R5: When `busrq_ni` is 0 at the sampling edge, a low `irq_ni` is ignored and `ie_o` keeps its value.
- R6: Counting the first cycle after acceptance as cycle 0, `iorq_no` is low from cycle 2 to the end of the last wait state. `mreq_no` and `rd_no` stay high throughout.
- R7: `m1_no` is low from cycle 0 to the end of the last wait state, which is 2 + AUTO_WAITS + n cycles in total, where n is the number of extra wait states.
- R8: An extra wait state is added each time `wait_ni` is 0 at the rising edge that ends the last automatic wait state or an extra wait state. The value of `wait_ni` in cycles 0 to AUTO_WAITS has no effect.
- R9: `data_i` is captured into `vec_o` at the edge that ends the last wait state. `vec_valid_o` is high for exactly the one following cycle, and `vec_o` holds its value afterwards.
- R10: `addr_o` equals `pc_i` outside the refresh phase. During the RFSH_CYC refresh cycles that follow the wait states, `addr_o` equals `rfsh_addr_i`, `rfsh_no` is low and `m1_no` and `iorq_no` are high.
- R11: `ie_set_i` sets `ie_o` on the next edge and `ie_clr_i` clears it. The clear wins when both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_end_i | input | 1 | High during the last clock of an instruction |
| irq_ni | input | 1 | Interrupt request level, active low |
| busrq_ni | input | 1 | Bus request, active low |
| ie_set_i | input | 1 | Set the interrupt enable flag |
| ie_clr_i | input | 1 | Clear the interrupt enable flag |
| wait_ni | input | 1 | External wait request, active low |
| data_i | input | DATA_W | Data bus carrying the response byte |
| pc_i | input | ADDR_W | Program counter |
| rfsh_addr_i | input | ADDR_W | Refresh address |
| addr_o | output | ADDR_W | Address bus |
| m1_no | output | 1 | Opcode-fetch cycle indicator, active low |
| mreq_no | output | 1 | Memory request strobe, active low |
| iorq_no | output | 1 | I/O request strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| rfsh_no | output | 1 | Refresh strobe, active low |
| ie_o | output | 1 | Interrupt enable flag |
| vec_o | output | DATA_W | Captured response byte |
| vec_valid_o | output | 1 | One-cycle pulse when `vec_o` is updated |

## Verification
The bench drives a low request while `instr_end_i` is 0, and again with the enable flag clear or a bus request pending. A design that samples too often or skips a gating term would start a cycle in one of these cases. Acknowledge cycles are run with zero, one and three extra wait states while `wait_ni` is held low during the early cycles. A sequencer that reads the wait input too soon, or counts the automatic wait states wrongly, would shift the I/O strobe window, the capture point and the refresh phase. The bench changes the data bus right after the capture and raises set and clear of the enable flag together. A latch that is not held, or the wrong priority between set and clear, would then show up at the outputs.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_WAUTO,
    ST_WEXT,
    ST_RFSH
  } ack_state_e;
endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic instr_end_i,
  input  logic irq_ni,
  input  logic busrq_ni,
  input  logic ie_set_i,
  input  logic ie_clr_i,
  output logic start_o,
  output logic ie_o
);
  logic ie_q;

  assign start_o = idle_i && instr_end_i && !irq_ni && busrq_ni && ie_q;
  assign ie_o    = ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ie_q <= 1'b0;
    else if (ie_clr_i || start_o) ie_q <= 1'b0;
    else if (ie_set_i)            ie_q <= 1'b1;
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_ack_pkg::*;
#(
  parameter int AUTO_WAITS = 2,
  parameter int RFSH_CYC   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wait_ni,
  output logic idle_o,
  output logic m1_act_o,
  output logic iorq_act_o,
  output logic rfsh_act_o,
  output logic latch_o
);
  localparam int MAX_CNT = (AUTO_WAITS > RFSH_CYC) ? AUTO_WAITS : RFSH_CYC;
  localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;
  localparam logic [CNT_W-1:0] AUTO_LAST = CNT_W'(AUTO_WAITS - 1);
  localparam logic [CNT_W-1:0] RFSH_LAST = CNT_W'(RFSH_CYC - 1);

  ack_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    latch_o = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_T1;
      ST_T1:    state_d = ST_T2;
      ST_T2: begin
        state_d = ST_WAUTO;
        cnt_d   = '0;
      end
      ST_WAUTO: begin
        if (cnt_q == AUTO_LAST) begin
          cnt_d = '0;
          if (wait_ni) begin
            state_d = ST_RFSH;
            latch_o = 1'b1;
          end else begin
            state_d = ST_WEXT;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WEXT: begin
        if (wait_ni) begin
          state_d = ST_RFSH;
          cnt_d   = '0;
          latch_o = 1'b1;
        end
      end
      ST_RFSH: begin
        if (cnt_q == RFSH_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign iorq_act_o = (state_q == ST_WAUTO) || (state_q == ST_WEXT);
  assign m1_act_o   = (state_q == ST_T1) || (state_q == ST_T2) || iorq_act_o;
  assign rfsh_act_o = (state_q == ST_RFSH);
endmodule

// File: rtl/irq_vec_latch.sv
module irq_vec_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= latch_i;
      if (latch_i) vec_o <= data_i;
    end
  end
endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux #(
  parameter int ADDR_W = 16
) (
  input  logic              m1_act_i,
  input  logic              iorq_act_i,
  input  logic              rfsh_act_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] rfsh_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              m1_no,
  output logic              mreq_no,
  output logic              iorq_no,
  output logic              rd_no,
  output logic              rfsh_no
);
  assign addr_o  = rfsh_act_i ? rfsh_addr_i : pc_i;
  assign m1_no   = !m1_act_i;
  assign iorq_no = !iorq_act_i;
  assign rfsh_no = !rfsh_act_i;
  // acknowledge cycle never asserts memory request or read
  assign mreq_no = 1'b1;
  assign rd_no   = 1'b1;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int AUTO_WAITS = 2,
  parameter int RFSH_CYC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_end_i,
  input  logic              irq_ni,
  input  logic              busrq_ni,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              wait_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] rfsh_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              m1_no,
  output logic              mreq_no,
  output logic              iorq_no,
  output logic              rd_no,
  output logic              rfsh_no,
  output logic              ie_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_valid_o
);
  logic idle, start, m1_act, iorq_act, rfsh_act, latch;

  irq_accept_gate i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (idle),
    .instr_end_i(instr_end_i),
    .irq_ni     (irq_ni),
    .busrq_ni   (busrq_ni),
    .ie_set_i   (ie_set_i),
    .ie_clr_i   (ie_clr_i),
    .start_o    (start),
    .ie_o       (ie_o)
  );

  irq_ack_fsm #(
    .AUTO_WAITS(AUTO_WAITS),
    .RFSH_CYC  (RFSH_CYC)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .wait_ni   (wait_ni),
    .idle_o    (idle),
    .m1_act_o  (m1_act),
    .iorq_act_o(iorq_act),
    .rfsh_act_o(rfsh_act),
    .latch_o   (latch)
  );

  irq_vec_latch #(.DATA_W(DATA_W)) i_vec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_i    (latch),
    .data_i     (data_i),
    .vec_o      (vec_o),
    .vec_valid_o(vec_valid_o)
  );

  irq_bus_mux #(.ADDR_W(ADDR_W)) i_mux (
    .m1_act_i   (m1_act),
    .iorq_act_i (iorq_act),
    .rfsh_act_i (rfsh_act),
    .pc_i       (pc_i),
    .rfsh_addr_i(rfsh_addr_i),
    .addr_o     (addr_o),
    .m1_no      (m1_no),
    .mreq_no    (mreq_no),
    .iorq_no    (iorq_no),
    .rd_no      (rd_no),
    .rfsh_no    (rfsh_no)
  );
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic instr_end_i,
  input logic irq_ni,
  input logic busrq_ni,
  input logic ie_clr_i,
  input logic m1_no,
  input logic iorq_no,
  input logic rfsh_no,
  input logic ie_o,
  input logic vec_valid_o
);
  logic idle;
  assign idle = m1_no && rfsh_no;

  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && instr_end_i && !irq_ni && busrq_ni && ie_o |=> !m1_no && !ie_o); // R2
  AST_NO_MIDINSTR_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !instr_end_i |=> m1_no); // R3
  AST_DISABLED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !ie_o |=> m1_no); // R4
  AST_BUSRQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !busrq_ni |=> m1_no); // R5
  AST_IORQ_IN_M1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iorq_no |-> !m1_no); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o); // R9
  AST_RFSH_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!m1_no, !rfsh_no})); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_clr_i |=> !ie_o); // R11
endmodule

bind irq_ack_seq irq_ack_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_end_i(instr_end_i),
  .irq_ni     (irq_ni),
  .busrq_ni   (busrq_ni),
  .ie_clr_i   (ie_clr_i),
  .m1_no      (m1_no),
  .iorq_no    (iorq_no),
  .rfsh_no    (rfsh_no),
  .ie_o       (ie_o),
  .vec_valid_o(vec_valid_o)
);

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int AUTO = 2;
  localparam int RFC = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic instr_end_i = 1'b0, irq_ni = 1'b1, busrq_ni = 1'b1;
  logic ie_set_i = 1'b0, ie_clr_i = 1'b0, wait_ni = 1'b1;
  logic [DW-1:0] data_i = '0;
  logic [AW-1:0] pc_i = 16'h1234, rfsh_addr_i = 16'h0055;
  logic [AW-1:0] addr_o;
  logic m1_no, mreq_no, iorq_no, rd_no, rfsh_no, ie_o, vec_valid_o;
  logic [DW-1:0] vec_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ack_seq i_irq_ack_seq (
    .clk_i(clk), .rst_ni(rst_ni), .instr_end_i(instr_end_i), .irq_ni(irq_ni),
    .busrq_ni(busrq_ni), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .wait_ni(wait_ni),
    .data_i(data_i), .pc_i(pc_i), .rfsh_addr_i(rfsh_addr_i), .addr_o(addr_o),
    .m1_no(m1_no), .mreq_no(mreq_no), .iorq_no(iorq_no), .rd_no(rd_no),
    .rfsh_no(rfsh_no), .ie_o(ie_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] strobes();
    return {m1_no, mreq_no, iorq_no, rd_no, rfsh_no};
  endfunction

  task automatic set_ie();
    @(negedge clk); ie_set_i = 1'b1;
    @(negedge clk); ie_set_i = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(strobes() == 5'h1f, "R1 strobes", strobes(), 5'h1f);
    chk(!ie_o && !vec_valid_o && vec_o == 0, "R1 ie/vec", {ie_o, vec_valid_o, vec_o}, 0);
  endtask

  // idle observation for several cycles: no cycle may start
  task automatic expect_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      instr_end_i = 1'b0;
      chk(m1_no && iorq_no && rfsh_no, req, strobes(), 5'h1f);
    end
  endtask

  task automatic test_mid_instr();
    set_ie();
    irq_ni = 1'b0;
    expect_idle(5, "R3 no sample off boundary");
    chk(ie_o, "R3 ie kept", ie_o, 1);
    irq_ni = 1'b1;
    instr_end_i = 1'b1;
    expect_idle(2, "R3 high request at boundary");
  endtask

  task automatic test_disabled();
    @(negedge clk); ie_clr_i = 1'b1;
    @(negedge clk); ie_clr_i = 1'b0; irq_ni = 1'b0; instr_end_i = 1'b1;
    expect_idle(3, "R4 disabled ignored");
    irq_ni = 1'b1;
  endtask

  task automatic test_busrq();
    set_ie();
    irq_ni = 1'b0; busrq_ni = 1'b0; instr_end_i = 1'b1;
    expect_idle(3, "R5 busrq ignored");
    chk(ie_o, "R5 ie kept", ie_o, 1);
    busrq_ni = 1'b1; irq_ni = 1'b1;
  endtask

  task automatic test_ie_prio();
    @(negedge clk); ie_set_i = 1'b1; ie_clr_i = 1'b1;
    @(negedge clk); ie_set_i = 1'b0; ie_clr_i = 1'b0;
    chk(!ie_o, "R11 clear wins", ie_o, 0);
    set_ie();
    chk(ie_o, "R11 set", ie_o, 1);
  endtask

  // full acknowledge cycle with n extra wait states
  task automatic run_ack(input int n, input logic [DW-1:0] vec);
    int last_w = 2 + AUTO + n;
    set_ie();
    @(negedge clk);
    irq_ni = 1'b0; instr_end_i = 1'b1; data_i = ~vec; wait_ni = 1'b0;
    for (int c = 0; c < last_w + RFC + 1; c++) begin
      @(negedge clk);
      instr_end_i = 1'b0;
      if (c == 0) chk(!ie_o, "R2 ie cleared", ie_o, 0);
      chk(m1_no == !(c < last_w), "R7 m1 window", m1_no, !(c < last_w));
      chk(iorq_no == !(c >= 2 && c < last_w), "R6 iorq window", iorq_no, !(c >= 2 && c < last_w));
      chk(mreq_no && rd_no, "R6 mreq/rd high", {mreq_no, rd_no}, 2'b11);
      chk(rfsh_no == !(c >= last_w && c < last_w + RFC), "R10 rfsh window", rfsh_no,
          !(c >= last_w && c < last_w + RFC));
      chk(addr_o == ((c >= last_w && c < last_w + RFC) ? rfsh_addr_i : pc_i), "R10 address",
          addr_o, (c >= last_w && c < last_w + RFC) ? rfsh_addr_i : pc_i);
      chk(vec_valid_o == (c == last_w), "R9 valid pulse", vec_valid_o, c == last_w);
      if (c >= last_w) chk(vec_o == vec, "R9 vector", vec_o, vec);
      // R8: wait low early has no effect; low at end of last auto wait adds states
      wait_ni = (c < last_w - 1) ? 1'b0 : 1'b1;
      data_i = (c == last_w - 1) ? vec : ~vec;
    end
    irq_ni = 1'b1;
    wait_ni = 1'b1;
    chk(strobes() == 5'h1f, "R8 cycle ended", strobes(), 5'h1f);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog R1-R11 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;
    test_reset();
    test_mid_instr();
    test_disabled();
    test_busrq();
    test_ie_prio();
    run_ack(0, 8'hA5);
    run_ack(1, 8'h3C);
    run_ack(3, 8'hF0);
    expect_idle(3, "R4 no restart after ack");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule